// File: doc/BRIEF.md
# Restoring Integer Divider

This block divides one N-bit integer by another over many cycles. It keeps a partial remainder and finds one quotient bit per cycle. In each cycle the partial remainder shifts left by one place and takes in the next dividend bit. The divisor is then subtracted from it as a trial. If the trial result is negative, the divisor is added back and the quotient bit is 0. Otherwise the trial result is kept and the quotient bit is 1.

A select input chooses unsigned or two's-complement operands. In signed mode both operands are first reduced to their magnitudes. The magnitudes are divided, and a final cycle corrects the signs of the quotient and the remainder.

The result appears on two words. The low word carries the quotient and the high word carries the remainder. A one-cycle completion strobe marks the result, and a flag reports a zero divisor. The result words and the flag hold their values until the next result.

Top module: `rdiv_unit`

## Requirements
- R1: Unsigned mode (`is_signed`=0): `result_lo` = floor(dividend / divisor) and `result_hi` = dividend − quotient·divisor, with `result_hi` < divisor.
- R2: Unsigned 74 (binary 1001010) divided by 8 (binary 1000) yields quotient 9 and remainder 2.
- R3: Signed mode (`is_signed`=1): the quotient is the magnitude quotient, negated when the operand signs differ (truncation toward zero). The remainder takes the sign of the dividend, and its magnitude is the magnitude remainder.
- R4: Signed most-negative value divided by −1 wraps to the most-negative value with remainder 0. Unsigned 2^(N−1) divided by all ones gives quotient 0 and remainder 2^(N−1).
- R5: A zero divisor, in either mode, produces `div_zero`=1, `result_lo` all ones and `result_hi` equal to the dividend. No iterations are run. A nonzero divisor produces `div_zero`=0.
- R6: `done` rises N+2 cycles after the clock edge that accepts `start`: one setup cycle, N iteration cycles and one fix-up cycle. For a zero divisor it rises 1 cycle after that edge.
- R7: `done` is high for exactly one cycle. `busy` is high from the cycle after acceptance up to the cycle before `done`, and it is low while `done` is high.
- R8: A `start` seen while `busy` is high is ignored. It neither restarts nor changes the current operation, and it produces no extra `done`.
- R9: After reset, `done`, `busy` and `div_zero` are 0 and both result words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division. Accepted only while idle |
| is_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend | input | N | Dividend, sampled when `start` is accepted |
| divisor | input | N | Divisor, sampled when `start` is accepted |
| result_lo | output | N | Quotient (low word) |
| result_hi | output | N | Remainder (high word) |
| done | output | 1 | One-cycle strobe: result words are valid |
| div_zero | output | 1 | The last result came from a zero divisor |
| busy | output | 1 | An operation is in progress |

## Verification
The scoreboard compares every result against a reference model built from the host's unsigned division on magnitudes. The corner cases it targets are these:
- Quotient bits that fall inside long runs of restores, such as all-ones or tiny divisors. A wrong shift or bring-down order gives a scrambled quotient.
- Mixed-sign signed operands. A misplaced fix-up truncates in the wrong direction or gives the remainder the divisor's sign.
- The most-negative value divided by −1. A design that saturates or misreads the magnitude of that value breaks here.
- A zero divisor. A design that loops anyway returns garbage late instead of all ones early.

A stray start injected mid-operation exposes a design that restarts, or that emits a second strobe.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_LOOP  = 2'd2,
        ST_FIX   = 2'd3
    } rdiv_state_e;
endpackage

// File: rtl/rdiv_abs.sv
// Magnitude of an operand; two's-complement negation only when signed mode
// is selected and the sign bit is set.
module rdiv_abs #(
    parameter int W = 32
) (
    input  logic [W-1:0] val,
    input  logic         signed_mode,
    output logic [W-1:0] mag,
    output logic         neg
);
    always_comb begin
        neg = signed_mode & val[W-1];
        mag = neg ? (~val + 1'b1) : val;
    end
endmodule

// File: rtl/rdiv_step.sv
// One restoring step: bring down a dividend bit, trial-subtract, restore on negative.
module rdiv_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] part_rem,
    input  logic         next_bit,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] rem_out,
    output logic         qbit
);
    // part_rem < dvs, so the trial result lies in (-2^W, 2^W): W+1 bits hold it.
    logic [W:0]   shifted;
    logic [W:0]   trial;
    logic [W-1:0] restored;

    always_comb begin
        shifted  = {part_rem, next_bit};
        trial    = shifted - {1'b0, dvs};
        restored = trial[W-1:0] + dvs;
        qbit     = ~trial[W];
        rem_out  = qbit ? trial[W-1:0] : restored;
    end
endmodule

// File: rtl/rdiv_fixup.sv
// Sign correction applied to the magnitude results.
module rdiv_fixup #(
    parameter int W = 32
) (
    input  logic [W-1:0] q_mag,
    input  logic [W-1:0] r_mag,
    input  logic         neg_q,
    input  logic         neg_r,
    output logic [W-1:0] q_out,
    output logic [W-1:0] r_out
);
    always_comb begin
        q_out = neg_q ? (~q_mag + 1'b1) : q_mag;
        r_out = neg_r ? (~r_mag + 1'b1) : r_mag;
    end
endmodule

// File: rtl/rdiv_unit.sv
module rdiv_unit
    import rdiv_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         is_signed,
    input  logic [N-1:0] dividend,
    input  logic [N-1:0] divisor,
    output logic [N-1:0] result_lo,
    output logic [N-1:0] result_hi,
    output logic         done,
    output logic         div_zero,
    output logic         busy
);
    localparam int CW = (N > 2) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    typedef struct packed {
        rdiv_state_e  st;
        logic [CW-1:0] cnt;
        logic          sgn;
        logic [N-1:0]  a_raw;
        logic [N-1:0]  b_raw;
        logic [N-1:0]  rem;
        logic [N-1:0]  quo;
        logic [N-1:0]  dvs;
        logic [N-1:0]  lo;
        logic [N-1:0]  hi;
        logic          done;
        logic          dz;
    } regs_t;

    regs_t r_q, r_d;

    logic [N-1:0] a_mag, b_mag, step_rem, fix_q, fix_r;
    logic         a_neg, b_neg, step_q;

    rdiv_abs #(.W(N)) u_abs_a (
        .val(r_q.a_raw), .signed_mode(r_q.sgn), .mag(a_mag), .neg(a_neg)
    );
    rdiv_abs #(.W(N)) u_abs_b (
        .val(r_q.b_raw), .signed_mode(r_q.sgn), .mag(b_mag), .neg(b_neg)
    );

    rdiv_step #(.W(N)) u_step (
        .part_rem(r_q.rem), .next_bit(r_q.quo[N-1]), .dvs(r_q.dvs),
        .rem_out(step_rem), .qbit(step_q)
    );

    rdiv_fixup #(.W(N)) u_fix (
        .q_mag(r_q.quo), .r_mag(r_q.rem), .neg_q(a_neg ^ b_neg), .neg_r(a_neg),
        .q_out(fix_q), .r_out(fix_r)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st    = ST_SETUP;
                    r_d.a_raw = dividend;
                    r_d.b_raw = divisor;
                    r_d.sgn   = is_signed;
                end
            end
            ST_SETUP: begin
                if (r_q.b_raw == '0) begin
                    r_d.st   = ST_IDLE;
                    r_d.lo   = '1;
                    r_d.hi   = r_q.a_raw;
                    r_d.dz   = 1'b1;
                    r_d.done = 1'b1;
                end else begin
                    r_d.st  = ST_LOOP;
                    r_d.cnt = '0;
                    r_d.rem = '0;
                    r_d.quo = a_mag;
                    r_d.dvs = b_mag;
                end
            end
            ST_LOOP: begin
                r_d.rem = step_rem;
                r_d.quo = {r_q.quo[N-2:0], step_q};
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == LAST) begin
                    r_d.st = ST_FIX;
                end
            end
            ST_FIX: begin
                r_d.st   = ST_IDLE;
                r_d.lo   = fix_q;
                r_d.hi   = fix_r;
                r_d.dz   = 1'b0;
                r_d.done = 1'b1;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= regs_t'('0);
        end else begin
            r_q <= r_d;
        end
    end

    assign result_lo = r_q.lo;
    assign result_hi = r_q.hi;
    assign done      = r_q.done;
    assign div_zero  = r_q.dz;
    assign busy      = (r_q.st != ST_IDLE);
endmodule

// File: rtl/rdiv_checker.sv
module rdiv_checker #(
    parameter int N = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         is_signed,
    input logic [N-1:0] dividend,
    input logic [N-1:0] divisor,
    input logic [N-1:0] result_lo,
    input logic [N-1:0] result_hi,
    input logic         done,
    input logic         div_zero,
    input logic         busy
);
    localparam int LW = $clog2(N + 4) + 1;

    logic [N-1:0]   lat_a, lat_b;
    logic           lat_s;
    logic [LW-1:0]  lat_cnt;
    logic [2*N-1:0] recon;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_a   <= '0;
            lat_b   <= '0;
            lat_s   <= 1'b0;
            lat_cnt <= '0;
        end else if (start && !busy) begin
            lat_a   <= dividend;
            lat_b   <= divisor;
            lat_s   <= is_signed;
            lat_cnt <= '0;
        end else if (busy) begin
            lat_cnt <= lat_cnt + 1'b1;
        end
    end

    always_comb begin
        recon = (2*N)'(result_lo) * (2*N)'(lat_b) + (2*N)'(result_hi);
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                   // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                                   // R7
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (div_zero == (lat_b == '0)));                             // R5
    AST_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_zero) |-> (result_lo == '1 && result_hi == lat_a));   // R5
    AST_UNSIGNED_EQ: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero && !lat_s) |->
            (recon == (2*N)'(lat_a) && result_hi < lat_b));                // R1
    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_cnt == (div_zero ? LW'(1) : LW'(N + 2))));           // R6
endmodule

bind rdiv_unit rdiv_checker #(.N(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
    .dividend(dividend), .divisor(divisor), .result_lo(result_lo),
    .result_hi(result_hi), .done(done), .div_zero(div_zero), .busy(busy)
);

// File: tb/rdiv_unit_test.sv
module rdiv_unit_test;
    localparam int N = 32;
    localparam logic [N-1:0] MINV = {1'b1, {(N-1){1'b0}}};

    typedef struct packed {
        logic [N-1:0] lo;
        logic [N-1:0] hi;
        logic         dz;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         is_signed = 1'b0;
    logic [N-1:0] dividend = '0;
    logic [N-1:0] divisor = '0;
    logic [N-1:0] result_lo, result_hi;
    logic         done, div_zero, busy;

    int checks = 0;
    int errors = 0;
    exp_t  sb_q[$];
    string tag_q[$];
    logic  prev_done = 1'b0;

    always #4 clk = ~clk;

    rdiv_unit #(.N(N)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
        .dividend(dividend), .divisor(divisor), .result_lo(result_lo),
        .result_hi(result_hi), .done(done), .div_zero(div_zero), .busy(busy)
    );

    task automatic chk(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [N-1:0] a, input logic [N-1:0] b,
                                   input logic s);
        exp_t e;
        logic an, bn;
        logic [N-1:0] am, bm, q, r;
        if (b == '0) begin
            e.lo = '1; e.hi = a; e.dz = 1'b1;
        end else begin
            an = s & a[N-1];
            bn = s & b[N-1];
            am = an ? -a : a;
            bm = bn ? -b : b;
            q  = am / bm;
            r  = am % bm;
            e.lo = (an ^ bn) ? -q : q;
            e.hi = an ? -r : r;
            e.dz = 1'b0;
        end
        return e;
    endfunction

    // Scoreboard monitor: pops one expected item per completion strobe.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected done", 64'(result_lo), 64'(0));
                end else begin
                    exp_t  e;
                    string t;
                    e = sb_q.pop_front();
                    t = tag_q.pop_front();
                    chk(result_lo == e.lo, {t, " quotient"}, 64'(result_lo), 64'(e.lo));
                    chk(result_hi == e.hi, {t, " remainder"}, 64'(result_hi), 64'(e.hi));
                    chk(div_zero == e.dz, {t, " R5 div_zero"}, 64'(div_zero), 64'(e.dz));
                end
            end
            if (done && prev_done) chk(1'b0, "R7 done longer than one cycle", 64'(1), 64'(0));
            prev_done = done;
        end
    end

    // Driver: pushes the expected result, pulses start, measures latency.
    task automatic run(input logic [N-1:0] a, input logic [N-1:0] b, input logic s,
                       input string tag, input bit inject);
        exp_t e;
        int   cnt;
        int   want;
        e = model(a, b, s);
        sb_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        dividend = a; divisor = b; is_signed = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 1;
        chk(busy == 1'b1, "R7 busy after accept", 64'(busy), 64'(1));
        while (!done && cnt < N + 10) begin
            @(negedge clk);
            cnt++;
            if (inject && cnt == 3) begin
                dividend = ~a; divisor = 32'd3; is_signed = ~s; start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        want = e.dz ? 2 : N + 3;
        chk(cnt == want, inject ? "R8 latency with stray start" : "R6 latency",
            64'(cnt), 64'(want));
        if (inject) begin
            for (int i = 0; i < N + 6; i++) @(negedge clk);
            chk(busy == 1'b0, "R8 no restart", 64'(busy), 64'(0));
            chk(result_lo == e.lo, "R8 result held", 64'(result_lo), 64'(e.lo));
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(done == 1'b0, "R9 done", 64'(done), 64'(0));
        chk(busy == 1'b0, "R9 busy", 64'(busy), 64'(0));
        chk(div_zero == 1'b0, "R9 div_zero", 64'(div_zero), 64'(0));
        chk(result_lo == '0, "R9 result_lo", 64'(result_lo), 64'(0));
        chk(result_hi == '0, "R9 result_hi", 64'(result_hi), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R2: bring-down example
        run(32'd74, 32'd8, 1'b0, "R2", 1'b0);
        chk(result_lo == 32'd9, "R2 quotient literal", 64'(result_lo), 64'(9));
        chk(result_hi == 32'd2, "R2 remainder literal", 64'(result_hi), 64'(2));

        // R1: unsigned patterns
        run(32'd100, 32'd7, 1'b0, "R1", 1'b0);
        run(32'hFFFF_FFFF, 32'd1, 1'b0, "R1", 1'b0);
        run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R1", 1'b0);
        run(32'd5, 32'd9, 1'b0, "R1", 1'b0);
        run(MINV, 32'd3, 1'b0, "R1", 1'b0);
        for (int i = 0; i < 40; i++) begin
            logic [N-1:0] a, b;
            a = $urandom;
            b = (i % 3 == 0) ? ($urandom & 32'hFF) : $urandom;
            if (b == '0) b = 32'd1;
            run(a, b, 1'b0, "R1", 1'b0);
        end

        // R3: signed patterns
        run(-32'sd7, 32'd2, 1'b1, "R3", 1'b0);
        run(32'd7, -32'sd2, 1'b1, "R3", 1'b0);
        run(-32'sd7, -32'sd2, 1'b1, "R3", 1'b0);
        run(32'd7, 32'd2, 1'b1, "R3", 1'b0);
        for (int i = 0; i < 40; i++) begin
            logic [N-1:0] a, b;
            a = $urandom;
            b = (i % 2 == 0) ? ($urandom | 32'hFFFF_FF00) : $urandom;
            if (b == '0) b = 32'd5;
            run(a, b, 1'b1, "R3", 1'b0);
        end

        // R4: most-negative corner
        run(MINV, 32'hFFFF_FFFF, 1'b1, "R4", 1'b0);
        chk(result_lo == MINV, "R4 wrap quotient", 64'(result_lo), 64'(MINV));
        chk(result_hi == '0, "R4 wrap remainder", 64'(result_hi), 64'(0));
        run(MINV, 32'hFFFF_FFFF, 1'b0, "R4", 1'b0);
        run(MINV, 32'd1, 1'b1, "R4", 1'b0);

        // R5: zero divisor, both modes
        run(32'h1234_5678, 32'd0, 1'b0, "R5", 1'b0);
        run(32'h8765_4321, 32'd0, 1'b1, "R5", 1'b0);
        chk(result_lo == '1, "R5 all ones", 64'(result_lo), 64'(32'hFFFF_FFFF));
        chk(result_hi == 32'h8765_4321, "R5 dividend", 64'(result_hi), 64'(32'h8765_4321));

        // R8: stray start while busy
        run(32'd1000, 32'd33, 1'b0, "R8", 1'b1);
        run(-32'sd1000, 32'd33, 1'b1, "R8", 1'b1);

        repeat (4) @(negedge clk);
        chk(sb_q.size() == 0, "R7 all results delivered", 64'(sb_q.size()), 64'(0));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule